// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block turns single-word access requests into bus cycles on a narrow processor-side interface. The address is 16 bits wide and the data 8 bits wide. The low address byte and the data byte share one set of eight pins. The shared pins are split into a driven value (`ad_out`), an output enable (`ad_oe`) and a sampled value (`ad_in`), so the pad ring or an enclosing wrapper builds the actual tristate buffer. The eight high address bits have their own dedicated pins. They carry no data.

A request is accepted only when the block is idle. Each accepted request runs a fixed sequence of four states. In the first state, ALE is high and the low address byte is on the shared pins, so an external transparent latch can capture it. In the second state, ALE drops and the pins turn around: they are released for a read, or start driving data for a write. In the third and fourth states, the active-low read or write strobe is asserted, together with an active-low memory-request or IO-request line. At the end of the fourth state, read data is sampled. In the following cycle, a one-cycle completion pulse is raised, and a new request may already be accepted in that same cycle.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, `ale` is 0, `rd_n`, `wr_n`, `mem_req_n` and `io_req_n` are 1, `ad_oe` is 0, `done` is 0, `rdata` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while idle. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_valid` and the request fields are ignored while a cycle is in progress.
- R3: In state 1 (the first cycle after acceptance), `ale` is 1, `ad_oe` is 1 and `ad_out` equals address bits 7:0. In every other cycle, `ale` is 0.
- R4: `addr_hi` equals address bits 15:8 of the accepted request in all four states, and it stays steady even if another request is presented meanwhile.
- R5: No strobe is asserted in state 1 or state 2. In particular, `rd_n` and `wr_n` are never 0 while `ale` is 1.
- R6: In a read (`req_write`=0), `rd_n` is 0 in states 3 and 4 and `wr_n` stays 1. `ad_oe` is 0 from state 2 through state 4.
- R7: In a write (`req_write`=1), `wr_n` is 0 in states 3 and 4 and `rd_n` stays 1. `ad_oe` is 1 and `ad_out` equals the write byte from state 2 through state 4.
- R8: `mem_req_n` (for `req_io`=0) or `io_req_n` (for `req_io`=1) is 0 exactly in the cycles where a strobe is 0. The two are never 0 together.
- R9: In a read, `rdata` takes the value of `ad_in` sampled at the end of state 4 and shows it in the cycle after state 4. `rdata` keeps its value through write cycles.
- R10: `done` is 1 for exactly the one cycle after state 4. The block is idle in that cycle, so back-to-back requests start every 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO space, 0 = memory space |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| ale | output | 1 | Address latch enable, high during the address state |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| mem_req_n | output | 1 | Active-low memory access marker |
| io_req_n | output | 1 | Active-low IO access marker |
| addr_hi | output | 8 | Dedicated high address byte |
| ad_out | output | 8 | Value driven onto the shared pins |
| ad_oe | output | 1 | Output enable of the shared pins |
| ad_in | input | 8 | Value sampled from the shared pins |

## Verification
The assertions assume that reset is held for at least a couple of clocks and that request fields are stable while `req_valid` is high. They assume nothing about `ad_in` or about when requests arrive. The stimulus changes inputs only on falling edges. It presents every request from an idle or completion cycle, and it deliberately presents extra requests during busy cycles to show they are ignored. The bench models the external device: it latches the low address byte while `ale` is high and returns a byte that is a fixed function of the full address only while `rd_n` is low. Reads sampled in the wrong state would therefore return a wrong value.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_TURN = 3'd2,
    ST_STRB = 3'd3,
    ST_SMPL = 3'd4
  } bus_state_e;
endpackage

// File: rtl/mbm_rst_sync.sv
module mbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbm_sequencer.sv
module mbm_sequencer
  import mbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output bus_state_e        state,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic              cur_io,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              done
);
  bus_state_e state_d;
  logic       take_en;
  logic       done_d;

  assign req_ready = (state == ST_IDLE);
  assign take_en   = req_valid && req_ready;
  assign done_d    = (state == ST_SMPL);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (take_en) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_TURN;
      ST_TURN: state_d = ST_STRB;
      ST_STRB: state_d = ST_SMPL;
      ST_SMPL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_io    <= 1'b0;
      cur_wdata <= '0;
    end else if (take_en) begin
      cur_addr  <= req_addr;
      cur_write <= req_write;
      cur_io    <= req_io;
      cur_wdata <= req_wdata;
    end
  end

  // R2: an accepted request starts the address state next cycle
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (state == ST_ADDR));

  // R2: request fields are held while busy
  p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cur_addr) || $past(state) == ST_IDLE);

  // R10: completion pulse lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done appears only right after the sample state
  p_done_after_smpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SMPL) |=> done && (state != ST_ADDR || $past(take_en)));
endmodule

// File: rtl/mbm_pin_drive.sv
module mbm_pin_drive
  import mbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_write,
  input  logic              cur_io,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mem_req_n,
  output logic              io_req_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic strobe_on;
  logic data_phase;
  logic rd_cap_en;

  assign strobe_on  = (state == ST_STRB) || (state == ST_SMPL);
  assign data_phase = (state == ST_TURN) || strobe_on;
  assign rd_cap_en  = (state == ST_SMPL) && !cur_write;

  always_comb begin
    ale       = (state == ST_ADDR);
    rd_n      = !(strobe_on && !cur_write);
    wr_n      = !(strobe_on &&  cur_write);
    mem_req_n = !(strobe_on && !cur_io);
    io_req_n  = !(strobe_on &&  cur_io);
    addr_hi   = cur_addr[ADDR_W-1 -: HI_W];
    ad_oe     = 1'b0;
    ad_out    = '0;
    if (state == ST_ADDR) begin
      ad_oe  = 1'b1;
      ad_out = cur_addr[DATA_W-1:0];
    end else if (data_phase && cur_write) begin
      ad_oe  = 1'b1;
      ad_out = cur_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_cap_en) begin
      rdata <= ad_in;
    end
  end

  // R5: no strobe while the address is on the shared pins
  p_no_strobe_in_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  // R3: ALE is a single-cycle pulse
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R5: strobe follows the ALE drop by a turnaround cycle
  p_strobe_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (rd_n && wr_n));

  // R6: pins released whenever the read strobe is active
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R7: pins driven whenever the write strobe is active
  p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R6/R7: strobes never together
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R8: exactly one space marker while a strobe is active, none otherwise
  p_space_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!mem_req_n, !io_req_n}) == ((!rd_n || !wr_n) ? 1 : 0));

  // R4: high address steady from ALE into the turnaround
  p_hi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> $stable(addr_hi));
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mem_req_n,
  output logic              io_req_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in
);
  logic              rst_sync_n;
  bus_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;
  logic              cur_io;
  logic [DATA_W-1:0] cur_wdata;

  mbm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sync_n)
  );

  mbm_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_io    (req_io),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .state     (state),
    .cur_addr  (cur_addr),
    .cur_write (cur_write),
    .cur_io    (cur_io),
    .cur_wdata (cur_wdata),
    .done      (done)
  );

  mbm_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .state     (state),
    .cur_addr  (cur_addr),
    .cur_write (cur_write),
    .cur_io    (cur_io),
    .cur_wdata (cur_wdata),
    .ad_in     (ad_in),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .mem_req_n (mem_req_n),
    .io_req_n  (io_req_n),
    .addr_hi   (addr_hi),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .rdata     (rdata)
  );
endmodule

// File: tb/mux_bus_master_test.sv
`timescale 1ns/1ps
module mux_bus_master_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic        req_write;
  logic        req_io;
  logic [7:0]  req_wdata;
  logic        done;
  logic [7:0]  rdata;
  logic        ale, rd_n, wr_n, mem_req_n, io_req_n;
  logic [7:0]  addr_hi;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  lat_lo;
  logic [7:0]  last_rd;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  mux_bus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .mem_req_n(mem_req_n), .io_req_n(io_req_n),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [7:0] dev_byte(input logic [7:0] lo, input logic [7:0] hi);
    return lo ^ {hi[3:0], hi[7:4]} ^ 8'hA5;
  endfunction

  // external device: answers only while the read strobe is low
  always_comb ad_in = (!rd_n) ? dev_byte(lat_lo, addr_hi) : 8'h00;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_pins(input string tag);
    chk({tag, " ale"}, 16'(ale), 16'd0);
    chk({tag, " rd_n"}, 16'(rd_n), 16'd1);
    chk({tag, " wr_n"}, 16'(wr_n), 16'd1);
    chk({tag, " mem_req_n"}, 16'(mem_req_n), 16'd1);
    chk({tag, " io_req_n"}, 16'(io_req_n), 16'd1);
    chk({tag, " ad_oe"}, 16'(ad_oe), 16'd0);
  endtask

  // called at a falling edge while the block is idle
  task automatic run_cycle(input logic [15:0] a, input bit wr, input bit io,
                           input logic [7:0] wd, input bit inject);
    logic rstb_exp, wstb_exp;
    chk("R10 ready before request", 16'(req_ready), 16'd1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_io = io; req_wdata = wd;
    @(negedge clk);
    // state 1
    lat_lo = ad_out;
    if (inject) begin
      req_addr = ~a; req_write = ~wr; req_io = ~io; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    chk("R3 ale in state1", 16'(ale), 16'd1);
    chk("R3 ad_oe in state1", 16'(ad_oe), 16'd1);
    chk("R3 low address", 16'(ad_out), 16'(a[7:0]));
    chk("R4 high address s1", 16'(addr_hi), 16'(a[15:8]));
    chk("R5 rd_n in state1", 16'(rd_n), 16'd1);
    chk("R5 wr_n in state1", 16'(wr_n), 16'd1);
    chk("R8 markers off s1", 16'({mem_req_n, io_req_n}), 16'h3);
    chk("R2 ready busy", 16'(req_ready), 16'd0);
    @(negedge clk);
    // state 2
    chk("R3 ale low s2", 16'(ale), 16'd0);
    chk("R5 no strobe s2", 16'({rd_n, wr_n}), 16'h3);
    chk("R8 markers off s2", 16'({mem_req_n, io_req_n}), 16'h3);
    chk(wr ? "R7 oe s2" : "R6 oe s2", 16'(ad_oe), 16'(wr));
    if (wr) chk("R7 data s2", 16'(ad_out), 16'(wd));
    chk("R4 high address s2", 16'(addr_hi), 16'(a[15:8]));
    rstb_exp = wr; wstb_exp = !wr;
    for (int s = 3; s <= 4; s++) begin
      @(negedge clk);
      chk("R3 ale low s3/4", 16'(ale), 16'd0);
      chk(wr ? "R7 rd_n" : "R6 rd_n", 16'(rd_n), 16'(rstb_exp));
      chk(wr ? "R7 wr_n" : "R6 wr_n", 16'(wr_n), 16'(wstb_exp));
      chk(wr ? "R7 oe" : "R6 oe", 16'(ad_oe), 16'(wr));
      if (wr) chk("R7 data", 16'(ad_out), 16'(wd));
      chk("R8 mem_req_n", 16'(mem_req_n), 16'(io));
      chk("R8 io_req_n", 16'(io_req_n), 16'(!io));
      chk("R4 high address", 16'(addr_hi), 16'(a[15:8]));
      chk("R10 done low", 16'(done), 16'd0);
      chk("R2 ready busy", 16'(req_ready), 16'd0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 done pulse", 16'(done), 16'd1);
    idle_pins("R10 after cycle");
    if (!wr) last_rd = dev_byte(a[7:0], a[15:8]);
    chk(wr ? "R9 rdata kept on write" : "R9 rdata", 16'(rdata), 16'(last_rd));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_io = 1'b0; req_wdata = '0; lat_lo = '0; last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_pins("R1 reset");
    chk("R1 done", 16'(done), 16'd0);
    chk("R1 rdata", 16'(rdata), 16'd0);
    chk("R1 ready", 16'(req_ready), 16'd1);

    // idle with no request: nothing starts
    repeat (3) @(negedge clk);
    idle_pins("R2 idle no request");

    // sweep all low bytes, all read/write and memory/IO combinations
    for (int i = 0; i < 256; i++) begin
      run_cycle({8'(i * 7 + 1), 8'(i)}, i[0], i[1], 8'(i * 13 + 5), (i % 16) == 3);
    end
    // corner addresses
    run_cycle(16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
    run_cycle(16'hFFFF, 1'b1, 1'b1, 8'hFF, 1'b1);
    run_cycle(16'hFFFF, 1'b0, 1'b1, 8'h00, 1'b0);
    run_cycle(16'h1234, 1'b1, 1'b0, 8'h5A, 1'b0);

    @(negedge clk);
    chk("R10 done single", 16'(done), 16'd0);
    idle_pins("R2 final idle");
    chk("R9 rdata held", 16'(rdata), 16'(last_rd));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule